// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block sequences the transfers between a static RAM and its nonvolatile shadow copy. Four sources can start a transfer: the supply coming up (recall), the supply failing (store), a shared active-low hardware store line, and a software request for a store or a recall. A dirty flag follows SRAM writes. A store started from the shared line is skipped when nothing has been written since the last transfer. While any transfer runs, the block blocks SRAM access and reports that it is busy. During a store it also pulls the shared line low, so that every other device tied to that line stores at the same time.

All durations are counted in clock cycles and set by parameters: the recall length, the store length, the shortest low pulse on the line that counts as a request, the delay from the line falling to access being blocked, and the recovery time after the line is released. The array model receives a one-cycle strobe at the start of each store or recall. After a power-fail store the block stays blocked until the supply is good again, and then it recalls.

Top module: `nv_xfer_seq`

## Requirements
- R1: While reset is held, and afterwards for as long as pwrGood stays low, inhibit is 1 and busy, pinPullDown, storeStrobe and recallStrobe are 0.
- R2: When pwrGood is high in the powered-off state, a recall begins on the next clock edge. recallStrobe is high for exactly that first cycle, busy is high for RECALL_CYC cycles, and inhibit then falls.
- R3: When pwrGood goes low while the block is idle, a store begins on the next edge whether or not the data is dirty. busy is high for STORE_CYC cycles, after which inhibit stays 1 and busy stays 0 until pwrGood rises.
- R4: When idle, a one-cycle swStoreReq starts a store (one storeStrobe, STORE_CYC busy cycles). A one-cycle swRecallReq starts a recall (one recallStrobe, RECALL_CYC busy cycles).
- R5: When swStoreReq and swRecallReq arrive in the same cycle, only the store runs.
- R6: Software requests that arrive during a transfer, or while powered off, have no effect. They produce no strobe and do not lengthen busy.
- R7: A low level on pinIn counts as a store request only after PIN_MIN_CYC consecutive low samples while idle. A shorter low pulse starts no transfer, and inhibit is 0 again one cycle after the pin returns high.
- R8: While idle, inhibit rises INH_DLY_CYC clock edges after pinIn goes low.
- R9: A store requested through pinIn runs (STORE_CYC busy cycles, one storeStrobe) only when the dirty flag is set. When the flag is clear, no strobe or busy occurs and the block goes straight to the held state.
- R10: After a pin-requested store, or after one that was skipped, inhibit stays 1 until pinIn reads high. It then stays 1 for RECOVER_CYC more cycles and falls on the cycle after.
- R11: pinPullDown is 1 in every cycle of every store, whatever started it, and 0 at all other times.
- R12: The dirty flag is set by sramWrite while idle and is cleared when a store or a recall completes. As a result, a pin request that follows a store or a recall with no write in between is skipped.
- R13: busy is never 1 while inhibit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrGood | input | 1 | Supply comparator, 1 = supply above threshold |
| swStoreReq | input | 1 | Software store request, sampled while idle |
| swRecallReq | input | 1 | Software recall request, sampled while idle |
| sramWrite | input | 1 | SRAM write indication, sets the dirty flag |
| pinIn | input | 1 | Level read back from the shared active-low store line |
| pinPullDown | output | 1 | 1 = drive the shared line low (open-drain) |
| inhibit | output | 1 | 1 = SRAM access blocked |
| busy | output | 1 | 1 = store or recall in progress |
| storeStrobe | output | 1 | One-cycle pulse at the start of a store |
| recallStrobe | output | 1 | One-cycle pulse at the start of a recall |

## Verification
The state register updates on the edge that samples a request, so busy, pinPullDown and the strobes appear one edge after a software or supply change. inhibit from the pin appears INH_DLY_CYC edges after the pin falls. A pin store starts one edge after the PIN_MIN_CYC-th low sample, and inhibit falls RECOVER_CYC+1 edges after the pin is released. The bench drives every input on the falling clock edge and samples after a known number of rising edges. For the directed timing checks it samples on both sides of the expected transition. The vector table instead counts busy, pull-down and strobe cycles over a window long enough for each transfer to finish, so that checks do not depend on the exact phase.

// File: rtl/nv_xfer_pkg.sv
package nv_xfer_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_RECALL,
    ST_IDLE,
    ST_STORE,
    ST_HOLD,
    ST_RECOVER
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadStore;
    logic loadRecall;
    logic loadRecover;
    logic clrDirty;
    logic idleOpen;
  } dpCtl_t;

endpackage

// File: rtl/nv_xfer_dpath.sv
module nv_xfer_dpath
  import nv_xfer_pkg::*;
#(
  parameter int STORE_CYC   = 24,
  parameter int RECALL_CYC  = 12,
  parameter int RECOVER_CYC = 3,
  parameter int PIN_MIN_CYC = 5,
  parameter int INH_DLY_CYC = 2,
  parameter int SYNC_STAGES = 0
) (
  input  logic   clk,
  input  logic   rstN,
  input  dpCtl_t ctl,
  input  logic   sramWrite,
  input  logic   pinIn,
  output logic   cntDone,
  output logic   dirty,
  output logic   pinReq,
  output logic   pinInh
);

  localparam int MAX_SR  = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int MAX_CYC = (MAX_SR > RECOVER_CYC) ? MAX_SR : RECOVER_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int PIN_W   = $clog2(PIN_MIN_CYC + 1);
  localparam int INH_EFF = (INH_DLY_CYC < PIN_MIN_CYC) ? INH_DLY_CYC : PIN_MIN_CYC;

  logic [CNT_W-1:0] cycCnt;
  logic [PIN_W-1:0] pinCnt;
  logic             pinSync;

  // optional resynchronisation of the shared line
  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign pinSync = pinIn;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= (syncQ << 1) | SYNC_STAGES'(pinIn);
      end
      assign pinSync = syncQ[SYNC_STAGES-1];
    end
  endgenerate

  // transfer / recovery duration counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cycCnt <= '0;
    else if (ctl.loadStore)   cycCnt <= CNT_W'(STORE_CYC - 1);
    else if (ctl.loadRecall)  cycCnt <= CNT_W'(RECALL_CYC - 1);
    else if (ctl.loadRecover) cycCnt <= CNT_W'(RECOVER_CYC - 1);
    else if (cycCnt != '0)    cycCnt <= cycCnt - CNT_W'(1);
  end
  assign cntDone = (cycCnt == '0);

  // write-dirty tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             dirty <= 1'b0;
    else if (ctl.clrDirty)                 dirty <= 1'b0;
    else if (ctl.idleOpen && sramWrite)    dirty <= 1'b1;
  end

  // qualification of the active-low line: consecutive low samples while idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinCnt <= '0;
    else if (ctl.idleOpen && !pinSync) begin
      if (pinCnt != PIN_W'(PIN_MIN_CYC)) pinCnt <= pinCnt + PIN_W'(1);
    end else begin
      pinCnt <= '0;
    end
  end

  assign pinReq = (pinCnt == PIN_W'(PIN_MIN_CYC));
  assign pinInh = (pinCnt >= PIN_W'(INH_EFF));

endmodule

// File: rtl/nv_xfer_ctrl.sv
module nv_xfer_ctrl
  import nv_xfer_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   pwrGood,
  input  logic   swStoreReq,
  input  logic   swRecallReq,
  input  logic   pinHigh,
  input  logic   cntDone,
  input  logic   dirty,
  input  logic   pinReq,
  input  logic   pinInh,
  output dpCtl_t ctl,
  output logic   inhibit,
  output logic   busy,
  output logic   pinPullDown,
  output logic   storeStrobe,
  output logic   recallStrobe
);

  seqState_t state, nxt;
  logic      fromPin, nxtFromPin;

  always_comb begin
    nxt        = state;
    nxtFromPin = fromPin;
    unique case (state)
      ST_OFF: begin
        if (pwrGood) nxt = ST_RECALL;
      end
      ST_RECALL: begin
        if (!pwrGood)    nxt = ST_OFF;
        else if (cntDone) nxt = ST_IDLE;
      end
      ST_IDLE: begin
        if (!pwrGood) begin
          nxt = ST_STORE; nxtFromPin = 1'b0;
        end else if (pinReq) begin
          if (dirty) begin
            nxt = ST_STORE; nxtFromPin = 1'b1;
          end else begin
            nxt = ST_HOLD;
          end
        end else if (swStoreReq) begin
          nxt = ST_STORE; nxtFromPin = 1'b0;
        end else if (swRecallReq) begin
          nxt = ST_RECALL;
        end
      end
      ST_STORE: begin
        if (cntDone) begin
          if (!pwrGood)     nxt = ST_OFF;
          else if (fromPin) nxt = ST_HOLD;
          else              nxt = ST_IDLE;
        end
      end
      ST_HOLD: begin
        if (!pwrGood) begin
          nxt = ST_STORE; nxtFromPin = 1'b0;
        end else if (pinHigh) begin
          nxt = ST_RECOVER;
        end
      end
      ST_RECOVER: begin
        if (!pwrGood) begin
          nxt = ST_STORE; nxtFromPin = 1'b0;
        end else if (cntDone) begin
          nxt = ST_IDLE;
        end
      end
      default: nxt = ST_OFF;
    endcase
  end

  always_comb begin
    ctl.loadStore   = (nxt == ST_STORE)   && (state != ST_STORE);
    ctl.loadRecall  = (nxt == ST_RECALL)  && (state != ST_RECALL);
    ctl.loadRecover = (nxt == ST_RECOVER) && (state != ST_RECOVER);
    ctl.clrDirty    = cntDone && ((state == ST_STORE) || (state == ST_RECALL));
    ctl.idleOpen    = (state == ST_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_OFF;
      fromPin      <= 1'b0;
      storeStrobe  <= 1'b0;
      recallStrobe <= 1'b0;
    end else begin
      state        <= nxt;
      fromPin      <= nxtFromPin;
      storeStrobe  <= ctl.loadStore;
      recallStrobe <= ctl.loadRecall;
    end
  end

  assign busy        = (state == ST_STORE) || (state == ST_RECALL);
  assign pinPullDown = (state == ST_STORE);
  assign inhibit     = (state != ST_IDLE) || pinInh;

endmodule

// File: rtl/nv_xfer_seq.sv
module nv_xfer_seq
  import nv_xfer_pkg::*;
#(
  parameter int STORE_CYC   = 24,
  parameter int RECALL_CYC  = 12,
  parameter int RECOVER_CYC = 3,
  parameter int PIN_MIN_CYC = 5,
  parameter int INH_DLY_CYC = 2,
  parameter int SYNC_STAGES = 0
) (
  input  logic clk,
  input  logic rstN,
  input  logic pwrGood,
  input  logic swStoreReq,
  input  logic swRecallReq,
  input  logic sramWrite,
  input  logic pinIn,
  output logic pinPullDown,
  output logic inhibit,
  output logic busy,
  output logic storeStrobe,
  output logic recallStrobe
);

  dpCtl_t ctl;
  logic   cntDone;
  logic   dirty;
  logic   pinReq;
  logic   pinInh;

  nv_xfer_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .pwrGood      (pwrGood),
    .swStoreReq   (swStoreReq),
    .swRecallReq  (swRecallReq),
    .pinHigh      (pinIn),
    .cntDone      (cntDone),
    .dirty        (dirty),
    .pinReq       (pinReq),
    .pinInh       (pinInh),
    .ctl          (ctl),
    .inhibit      (inhibit),
    .busy         (busy),
    .pinPullDown  (pinPullDown),
    .storeStrobe  (storeStrobe),
    .recallStrobe (recallStrobe)
  );

  nv_xfer_dpath #(
    .STORE_CYC   (STORE_CYC),
    .RECALL_CYC  (RECALL_CYC),
    .RECOVER_CYC (RECOVER_CYC),
    .PIN_MIN_CYC (PIN_MIN_CYC),
    .INH_DLY_CYC (INH_DLY_CYC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .sramWrite (sramWrite),
    .pinIn     (pinIn),
    .cntDone   (cntDone),
    .dirty     (dirty),
    .pinReq    (pinReq),
    .pinInh    (pinInh)
  );

endmodule

// File: rtl/nv_xfer_chk.sv
module nv_xfer_chk (
  input logic clk,
  input logic rstN,
  input logic pwrGood,
  input logic pinPullDown,
  input logic inhibit,
  input logic busy,
  input logic storeStrobe,
  input logic recallStrobe
);

  assert_busy_inhibit_R13: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> inhibit);

  assert_pull_in_store_R11: assert property (@(posedge clk) disable iff (!rstN)
    pinPullDown |-> (busy && !recallStrobe));

  assert_store_strobe_pull_R11: assert property (@(posedge clk) disable iff (!rstN)
    storeStrobe |-> pinPullDown);

  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(storeStrobe && recallStrobe));

  assert_recall_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    recallStrobe |=> !recallStrobe);

  assert_busy_start_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (storeStrobe || recallStrobe));

  assert_power_low_inhibit_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!pwrGood && $past(!pwrGood)) |-> inhibit);

  always_comb begin
    if (rstN) begin
      assert_strobe_busy_R4: assert (!(storeStrobe || recallStrobe) || busy);
    end
  end

endmodule

bind nv_xfer_seq nv_xfer_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .pwrGood      (pwrGood),
  .pinPullDown  (pinPullDown),
  .inhibit      (inhibit),
  .busy         (busy),
  .storeStrobe  (storeStrobe),
  .recallStrobe (recallStrobe)
);

// File: tb/sim_nv_xfer_seq.sv
`timescale 1ns/1ps
module sim_nv_xfer_seq;

  localparam int ST = 24;
  localparam int RC = 12;
  localparam int RV = 3;
  localparam int PM = 5;
  localparam int ID = 2;
  localparam int WIN = ST + PM + RV + 10;

  typedef struct packed {
    logic [1:0]  kind;     // 0 sw store, 1 sw recall, 2 both, 3 pin
    logic        wr;
    logic        expSt;
    logic        expRc;
    logic [15:0] expBusy;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 1'b1, 1'b1, 1'b0, 16'(ST)},  // R4 store
    '{2'd3, 1'b0, 1'b0, 1'b0, 16'd0},    // R12 cleared by store -> skip
    '{2'd3, 1'b1, 1'b1, 1'b0, 16'(ST)},  // R9 dirty pin store
    '{2'd1, 1'b1, 1'b0, 1'b1, 16'(RC)},  // R4 recall
    '{2'd3, 1'b0, 1'b0, 1'b0, 16'd0},    // R12 cleared by recall -> skip
    '{2'd2, 1'b0, 1'b1, 1'b0, 16'(ST)},  // R5 store wins
    '{2'd1, 1'b0, 1'b0, 1'b1, 16'(RC)}   // R4 recall
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwrGood = 1'b0;
  logic swStoreReq = 1'b0;
  logic swRecallReq = 1'b0;
  logic sramWrite = 1'b0;
  logic extLow = 1'b0;
  logic pinIn;
  logic pinPullDown, inhibit, busy, storeStrobe, recallStrobe;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  assign pinIn = !(extLow || pinPullDown);

  nv_xfer_seq #(
    .STORE_CYC(ST), .RECALL_CYC(RC), .RECOVER_CYC(RV),
    .PIN_MIN_CYC(PM), .INH_DLY_CYC(ID), .SYNC_STAGES(0)
  ) u0 (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood),
    .swStoreReq(swStoreReq), .swRecallReq(swRecallReq),
    .sramWrite(sramWrite), .pinIn(pinIn), .pinPullDown(pinPullDown),
    .inhibit(inhibit), .busy(busy), .storeStrobe(storeStrobe),
    .recallStrobe(recallStrobe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  function automatic string tagOf(input vec_t v);
    if (v.kind == 2'd3) return v.wr ? "R9" : "R12";
    if (v.kind == 2'd2) return "R5";
    return "R4";
  endfunction

  task automatic runVec(input vec_t v, input int idx);
    int nBusy = 0, nSt = 0, nRc = 0, nPull = 0;
    if (v.wr) begin
      sramWrite = 1'b1; step(1); sramWrite = 1'b0;
    end
    case (v.kind)
      2'd0: swStoreReq = 1'b1;
      2'd1: swRecallReq = 1'b1;
      2'd2: begin swStoreReq = 1'b1; swRecallReq = 1'b1; end
      default: extLow = 1'b1;
    endcase
    for (int c = 0; c < WIN; c++) begin
      step(1);
      swStoreReq = 1'b0;
      swRecallReq = 1'b0;
      if (c == PM + 2) extLow = 1'b0;
      nBusy += int'(busy);
      nSt   += int'(storeStrobe);
      nRc   += int'(recallStrobe);
      nPull += int'(pinPullDown);
    end
    chk($sformatf("%s vec%0d busy cycles", tagOf(v), idx), nBusy, int'(v.expBusy));
    chk($sformatf("%s vec%0d store strobes", tagOf(v), idx), nSt, int'(v.expSt));
    chk($sformatf("%s vec%0d recall strobes", tagOf(v), idx), nRc, int'(v.expRc));
    chk($sformatf("R11 vec%0d pull-down cycles", idx), nPull, v.expSt ? ST : 0);
    chk($sformatf("R10 vec%0d inhibit released", idx), int'(inhibit), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int nBusy, nSt, nRc, nPull, nBad;
    // R1 reset state
    step(3);
    chk("R1 reset inhibit", int'(inhibit), 1);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset pull-down", int'(pinPullDown), 0);
    chk("R1 reset strobes", int'(storeStrobe || recallStrobe), 0);
    rstN = 1'b1;
    step(3);
    chk("R1 off inhibit", int'(inhibit), 1);
    chk("R1 off busy", int'(busy), 0);

    // R2 power-up recall, exact timing
    pwrGood = 1'b1;
    step(1);
    chk("R2 busy first", int'(busy), 1);
    chk("R2 strobe first", int'(recallStrobe), 1);
    step(1);
    chk("R2 strobe second", int'(recallStrobe), 0);
    step(RC - 2);
    chk("R2 busy last", int'(busy), 1);
    step(1);
    chk("R2 busy done", int'(busy), 0);
    chk("R2 inhibit done", int'(inhibit), 0);

    // vector table
    for (int i = 0; i < NVEC; i++) runVec(VECS[i], i);

    // R6 requests while busy
    nBusy = 0; nSt = 0; nRc = 0; nBad = 0;
    swStoreReq = 1'b1;
    for (int c = 0; c < ST + 8; c++) begin
      step(1);
      swStoreReq = 1'b0;
      swRecallReq = 1'b0;
      if (c == 3) begin swStoreReq = 1'b1; swRecallReq = 1'b1; end
      nBusy += int'(busy);
      nSt   += int'(storeStrobe);
      nRc   += int'(recallStrobe);
      nBad  += int'(busy && !inhibit);
    end
    chk("R6 busy not extended", nBusy, ST);
    chk("R6 single store strobe", nSt, 1);
    chk("R6 recall ignored", nRc, 0);
    chk("R13 busy without inhibit", nBad, 0);

    // R8 / R10 pin timing with clean data
    extLow = 1'b1;
    if (ID > 1) begin
      step(ID - 1);
      chk("R8 inhibit before delay", int'(inhibit), 0);
      step(1);
    end else begin
      step(1);
    end
    chk("R8 inhibit at delay", int'(inhibit), 1);
    step(PM + 1 - ID);
    chk("R9 clean skip busy", int'(busy), 0);
    chk("R9 clean skip pull-down", int'(pinPullDown), 0);
    step(4);
    chk("R10 held while pin low", int'(inhibit), 1);
    extLow = 1'b0;
    step(RV);
    chk("R10 recover inhibit", int'(inhibit), 1);
    step(1);
    chk("R10 recover done", int'(inhibit), 0);

    // R7 short pulse with dirty data
    sramWrite = 1'b1; step(1); sramWrite = 1'b0;
    extLow = 1'b1;
    step(PM - 1);
    extLow = 1'b0;
    step(1);
    chk("R7 inhibit after short pulse", int'(inhibit), 0);
    nBusy = 0; nSt = 0;
    for (int c = 0; c < 10; c++) begin
      step(1);
      nBusy += int'(busy);
      nSt   += int'(storeStrobe);
    end
    chk("R7 short pulse no busy", nBusy, 0);
    chk("R7 short pulse no strobe", nSt, 0);

    // R3 power-fail store
    pwrGood = 1'b0;
    nBusy = 0; nSt = 0; nPull = 0;
    for (int c = 0; c < ST + 6; c++) begin
      step(1);
      nBusy += int'(busy);
      nSt   += int'(storeStrobe);
      nPull += int'(pinPullDown);
    end
    chk("R3 store busy", nBusy, ST);
    chk("R3 store strobe", nSt, 1);
    chk("R11 power store pull-down", nPull, ST);
    chk("R3 off inhibit", int'(inhibit), 1);
    chk("R3 off busy", int'(busy), 0);

    // R6 software request while off
    swStoreReq = 1'b1;
    step(2);
    swStoreReq = 1'b0;
    chk("R6 off ignores request", int'(busy || storeStrobe), 0);

    // R2 second power-up
    pwrGood = 1'b1;
    nBusy = 0; nRc = 0;
    for (int c = 0; c < RC + 4; c++) begin
      step(1);
      nBusy += int'(busy);
      nRc   += int'(recallStrobe);
    end
    chk("R2 repower busy", nBusy, RC);
    chk("R2 repower strobe", nRc, 1);
    chk("R2 repower inhibit", int'(inhibit), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule